// File: doc/BRIEF.md
# Dual Output Overlap Delay Generator

This block turns one pulse-width request into two in-phase gate-control signals for a forward converter. The main output drives the primary switch. The auxiliary output drives an active clamp switch or a synchronous rectifier. The auxiliary output always brackets the main output: it rises a programmable number of clock cycles before the main output rises, and it falls the same number of cycles after the main output falls. This keeps the two switches from conducting at the wrong time.

The overlap is a count of clock cycles held in a small setting register. Reset loads a default count, and a write strobe replaces it. A count of zero acts as one cycle. Values above a parameter cap are clipped to the cap, so the overlap can never push the auxiliary output to full duty.

A fault line drops both outputs on the next clock edge with no overlap. A duty guard limits how long the auxiliary output can stay high. When that limit is reached, the guard clips both outputs and sets a sticky flag. The outputs then stay low until the request is withdrawn.

Top module: `overlap_drv`

## Requirements
- R1: After reset, out_main, out_aux and aux_clipped are 0, and the overlap setting equals DLY_DEFAULT (20 cycles).
- R2: When pwm_req is sampled high in idle, out_aux rises at that edge, and out_main rises D edges later, where D is the effective overlap.
- R3: When pwm_req is sampled low while out_main is high, out_main falls at that edge, and out_aux falls D edges later.
- R4: out_main is never high while out_aux is low.
- R5: A dly_wr pulse stores dly_val. Each phase copies the setting when its count starts, so a write changes only the phases that begin after it. A stored 0 acts as 1, and a value above DLY_CAP (40) acts as DLY_CAP.
- R6: While fault is sampled high, both outputs are 0 from that edge on, with no overlap applied.
- R7: If pwm_req is sampled low before out_main has risen, out_main stays low for that pulse, and out_aux falls D edges after that edge.
- R8: out_aux is never high for more than AUX_MAX (100) consecutive cycles. At that limit both outputs fall together and aux_clipped becomes 1 and stays 1 until reset. The outputs stay low until pwm_req has been sampled low.
- R9: A rising pwm_req during the trailing overlap does not cut that overlap short. out_aux completes its delayed fall, then rises again one edge later if pwm_req is still high.
- R10: If fault is sampled high on the edge at which out_main would have risen, both outputs go low and out_main does not rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_req | input | 1 | Raw pulse-width drive request |
| fault | input | 1 | Immediate disable, high active |
| dly_wr | input | 1 | Strobe that stores dly_val as the overlap setting |
| dly_val | input | DLY_W | New overlap setting in clock cycles |
| out_main | output | 1 | Main switch drive |
| out_aux | output | 1 | Auxiliary (clamp or rectifier) drive |
| aux_clipped | output | 1 | Sticky flag: the duty guard has cut a pulse |

## Verification
Two pairs of functions can act on the same edge, and the bench provokes both. In the first, the fault line rises on exactly the edge where the leading overlap count expires and out_main would turn on. The result passes if both outputs are low after that edge and out_main never showed a high cycle. In the second, the request rises again while the trailing overlap is still counting. The result passes if out_aux completes its full delayed fall, shows exactly one low cycle, and then starts a fresh leading overlap.

// File: rtl/odg_pkg.sv
package odg_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_LEAD  = 3'd1,
      PH_ON    = 3'd2,
      PH_TRAIL = 3'd3,
      PH_HOLD  = 3'd4
   } odg_phase_e;

endpackage

// File: rtl/odg_delay_cfg.sv
module odg_delay_cfg #(
   parameter int DLY_W       = 8,
   parameter int DLY_DEFAULT = 20,
   parameter int DLY_CAP     = 40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dly_wr,
   input  logic [DLY_W-1:0] dly_val,
   output logic [DLY_W-1:0] dly_eff
);

   localparam int          FULL_SCALE = (1 << DLY_W) - 1;
   localparam logic [DLY_W-1:0] RST_VAL = DLY_W'(DLY_DEFAULT);
   localparam logic [DLY_W-1:0] CAP_VAL = DLY_W'(DLY_CAP);
   localparam logic [DLY_W-1:0] ONE_VAL = DLY_W'(1);

   logic [DLY_W-1:0] setting_q;
   logic [DLY_W-1:0] floored;

   initial begin
      assert (DLY_W >= 2) else $error("odg_delay_cfg: DLY_W too small");
      assert (DLY_CAP >= 1 && DLY_CAP <= FULL_SCALE)
         else $error("odg_delay_cfg: DLY_CAP out of range");
      assert (DLY_DEFAULT >= 0 && DLY_DEFAULT <= FULL_SCALE)
         else $error("odg_delay_cfg: DLY_DEFAULT out of range");
   end

   // setting register, default loaded by reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         setting_q <= RST_VAL;
      else if (dly_wr)
         setting_q <= dly_val;
   end

   // zero means the shortest overlap of one cycle
   always_comb begin
      floored = (setting_q == '0) ? ONE_VAL : setting_q;
   end

   generate
      if (DLY_CAP >= FULL_SCALE) begin : g_no_cap
         assign dly_eff = floored;
      end else begin : g_cap
         assign dly_eff = (floored > CAP_VAL) ? CAP_VAL : floored;
      end
   endgenerate

   // R5: the effective overlap always lies in 1..DLY_CAP
   p_dly_range_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (dly_eff >= ONE_VAL) && (dly_eff <= CAP_VAL));

endmodule

// File: rtl/odg_duty_guard.sv
module odg_duty_guard #(
   parameter int AUX_MAX  = 100,
   parameter bit GUARD_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic out_aux,
   input  logic fault,
   output logic clip_now,
   output logic clipped
);

   localparam int RUN_W = $clog2(AUX_MAX + 1);
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(AUX_MAX - 1);
   localparam logic [RUN_W-1:0] RUN_LIM  = RUN_W'(AUX_MAX);

   initial begin
      assert (AUX_MAX >= 4) else $error("odg_duty_guard: AUX_MAX too small");
   end

   generate
      if (GUARD_EN) begin : g_guard
         logic [RUN_W-1:0] run_q;
         logic             flag_q;

         // counts the cycles out_aux has already been high
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               run_q <= '0;
            else if (out_aux && !clip_now)
               run_q <= run_q + RUN_W'(1);
            else
               run_q <= '0;
         end

         assign clip_now = out_aux && (run_q == RUN_LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               flag_q <= 1'b0;
            else if (clip_now && !fault)
               flag_q <= 1'b1;
         end

         assign clipped = flag_q;

         // R8: the high-time counter never reaches the limit while out_aux is high
         p_aux_cap_r8 : assert property (@(posedge clk) disable iff (!rst_n)
            out_aux |-> (run_q < RUN_LIM));

         // R8: once set, the flag stays set
         p_flag_sticky_r8 : assert property (@(posedge clk) disable iff (!rst_n)
            flag_q |=> flag_q);
      end else begin : g_no_guard
         assign clip_now = 1'b0;
         assign clipped  = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/odg_phase_seq.sv
module odg_phase_seq
   import odg_pkg::*;
#(
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwm_req,
   input  logic             fault,
   input  logic             clip_now,
   input  logic [DLY_W-1:0] dly_eff,
   output logic             out_main,
   output logic             out_aux
);

   localparam logic [DLY_W-1:0] CNT_ONE = DLY_W'(1);

   odg_phase_e       phase_q, phase_d;
   logic [DLY_W-1:0] cnt_q, cnt_d;
   logic             main_q, main_d;
   logic             aux_q, aux_d;

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q;
      main_d  = main_q;
      aux_d   = aux_q;
      if (fault) begin
         // immediate disable, no overlap
         phase_d = PH_IDLE;
         cnt_d   = '0;
         main_d  = 1'b0;
         aux_d   = 1'b0;
      end else if (clip_now) begin
         phase_d = PH_HOLD;
         cnt_d   = '0;
         main_d  = 1'b0;
         aux_d   = 1'b0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (pwm_req) begin
                  phase_d = PH_LEAD;
                  aux_d   = 1'b1;
                  cnt_d   = dly_eff;
               end
            end
            PH_LEAD: begin
               if (!pwm_req) begin
                  // aborted pulse: main never turns on
                  phase_d = PH_TRAIL;
                  cnt_d   = dly_eff;
               end else if (cnt_q == CNT_ONE) begin
                  phase_d = PH_ON;
                  main_d  = 1'b1;
               end else begin
                  cnt_d = cnt_q - CNT_ONE;
               end
            end
            PH_ON: begin
               if (!pwm_req) begin
                  phase_d = PH_TRAIL;
                  main_d  = 1'b0;
                  cnt_d   = dly_eff;
               end
            end
            PH_TRAIL: begin
               if (cnt_q == CNT_ONE) begin
                  phase_d = PH_IDLE;
                  aux_d   = 1'b0;
               end else begin
                  cnt_d = cnt_q - CNT_ONE;
               end
            end
            PH_HOLD: begin
               if (!pwm_req)
                  phase_d = PH_IDLE;
            end
            default: begin
               phase_d = PH_IDLE;
               main_d  = 1'b0;
               aux_d   = 1'b0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         main_q  <= 1'b0;
         aux_q   <= 1'b0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
         main_q  <= main_d;
         aux_q   <= aux_d;
      end
   end

   assign out_main = main_q;
   assign out_aux  = aux_q;

   // R4: main only while auxiliary is on
   p_main_under_aux_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      out_main |-> out_aux);

   // R2: auxiliary already high in the cycle before main rises
   p_aux_leads_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_main) |-> $past(out_aux));

   // R6: fault clears both outputs at the next edge
   p_fault_drop_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (!out_main && !out_aux));

   // R3: a normal auxiliary fall happens only after main was already low
   p_aux_trails_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(out_aux) && !$past(fault) && !$past(clip_now)) |-> !$past(out_main));

endmodule

// File: rtl/overlap_drv.sv
module overlap_drv #(
   parameter int DLY_W       = 8,
   parameter int DLY_DEFAULT = 20,
   parameter int DLY_CAP     = 40,
   parameter int AUX_MAX     = 100,
   parameter bit GUARD_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwm_req,
   input  logic             fault,
   input  logic             dly_wr,
   input  logic [DLY_W-1:0] dly_val,
   output logic             out_main,
   output logic             out_aux,
   output logic             aux_clipped
);

   logic [DLY_W-1:0] dly_eff;
   logic             clip_now;

   initial begin
      assert (AUX_MAX > 2 * DLY_CAP)
         else $error("overlap_drv: cap leaves no room for main on-time");
   end

   odg_delay_cfg #(
      .DLY_W       (DLY_W),
      .DLY_DEFAULT (DLY_DEFAULT),
      .DLY_CAP     (DLY_CAP)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .dly_wr  (dly_wr),
      .dly_val (dly_val),
      .dly_eff (dly_eff)
   );

   odg_phase_seq #(
      .DLY_W (DLY_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwm_req  (pwm_req),
      .fault    (fault),
      .clip_now (clip_now),
      .dly_eff  (dly_eff),
      .out_main (out_main),
      .out_aux  (out_aux)
   );

   odg_duty_guard #(
      .AUX_MAX  (AUX_MAX),
      .GUARD_EN (GUARD_EN)
   ) u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .out_aux  (out_aux),
      .fault    (fault),
      .clip_now (clip_now),
      .clipped  (aux_clipped)
   );

   // R10: a fault on the expiry edge keeps main from ever rising
   p_fault_beats_rise_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> !out_main);

endmodule

// File: tb/overlap_drv_tb.sv
module overlap_drv_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwm_req = 1'b0;
   logic       fault = 1'b0;
   logic       dly_wr = 1'b0;
   logic [7:0] dly_val = '0;
   logic       out_main, out_aux, aux_clipped;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   overlap_drv u_dut (
      .clk(clk), .rst_n(rst_n), .pwm_req(pwm_req), .fault(fault),
      .dly_wr(dly_wr), .dly_val(dly_val),
      .out_main(out_main), .out_aux(out_aux), .aux_clipped(aux_clipped)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic set_dly(int v);
      dly_val = 8'(v);
      dly_wr  = 1'b1;
      step();
      dly_wr  = 1'b0;
   endtask

   // full pulse with overlap d, checking both edges
   task automatic pulse(int d, int on_cycles, string tag);
      pwm_req = 1'b1;
      step();
      chk({tag, " R2 aux rise"}, out_aux, 1'b1);
      chk({tag, " R2 main waits"}, out_main, 1'b0);
      for (int i = 1; i < d; i++) begin
         step();
         chk({tag, " R2 main still low"}, out_main, 1'b0);
      end
      step();
      chk({tag, " R2 main rise"}, out_main, 1'b1);
      repeat (on_cycles) step();
      pwm_req = 1'b0;
      step();
      chk({tag, " R3 main fall"}, out_main, 1'b0);
      chk({tag, " R3 aux holds"}, out_aux, 1'b1);
      for (int i = 1; i < d; i++) begin
         step();
         chk({tag, " R3 aux still high"}, out_aux, 1'b1);
      end
      step();
      chk({tag, " R3 aux fall"}, out_aux, 1'b0);
   endtask

   task automatic t_reset();
      chk("R1 main after reset", out_main, 1'b0);
      chk("R1 aux after reset", out_aux, 1'b0);
      chk("R1 flag after reset", aux_clipped, 1'b0);
   endtask

   task automatic t_default();
      pulse(20, 5, "R1 default");
   endtask

   task automatic t_settings();
      set_dly(3);
      pulse(3, 4, "R5 d3");
      set_dly(0);
      pulse(1, 2, "R5 zero");
      set_dly(200);
      pulse(40, 2, "R5 cap");
   endtask

   task automatic t_mid_write();
      set_dly(3);
      pwm_req = 1'b1;
      repeat (4) step();
      chk("R5 mid main on", out_main, 1'b1);
      set_dly(5);
      pwm_req = 1'b0;
      step();
      chk("R5 mid main fall", out_main, 1'b0);
      repeat (4) begin
         step();
         chk("R5 new trail aux high", out_aux, 1'b1);
      end
      step();
      chk("R5 new trail aux fall", out_aux, 1'b0);
   endtask

   task automatic t_fault();
      set_dly(3);
      pwm_req = 1'b1;
      repeat (6) step();
      chk("R6 pre main", out_main, 1'b1);
      fault = 1'b1;
      step();
      chk("R6 main dropped", out_main, 1'b0);
      chk("R6 aux dropped", out_aux, 1'b0);
      repeat (5) begin
         step();
         chk("R6 held aux", out_aux, 1'b0);
      end
      fault = 1'b0;
      step();
      chk("R6 restart aux", out_aux, 1'b1);
      pwm_req = 1'b0;
      repeat (6) step();
      chk("R6 idle again", out_aux, 1'b0);
   endtask

   task automatic t_abort();
      set_dly(6);
      pwm_req = 1'b1;
      repeat (3) begin
         step();
         chk("R7 main suppressed lead", out_main, 1'b0);
      end
      pwm_req = 1'b0;
      step();
      chk("R7 aux held", out_aux, 1'b1);
      for (int i = 1; i < 6; i++) begin
         step();
         chk("R7 main never", out_main, 1'b0);
         chk("R7 aux trail", out_aux, 1'b1);
      end
      step();
      chk("R7 aux fall", out_aux, 1'b0);
   endtask

   task automatic t_retrigger();
      set_dly(4);
      pwm_req = 1'b1;
      repeat (6) step();
      pwm_req = 1'b0;
      step();
      chk("R9 main fall", out_main, 1'b0);
      step();
      pwm_req = 1'b1;
      step();
      chk("R9 trail kept e2", out_aux, 1'b1);
      step();
      chk("R9 trail kept e3", out_aux, 1'b1);
      step();
      chk("R9 aux fall", out_aux, 1'b0);
      step();
      chk("R9 aux restart", out_aux, 1'b1);
      chk("R9 main waits", out_main, 1'b0);
      pwm_req = 1'b0;
      repeat (8) step();
      chk("R9 idle", out_aux, 1'b0);
   endtask

   task automatic t_coincide();
      set_dly(3);
      pwm_req = 1'b1;
      step();
      step();
      step();
      chk("R10 main before expiry", out_main, 1'b0);
      fault = 1'b1;
      step();
      chk("R10 main blocked", out_main, 1'b0);
      chk("R10 aux dropped", out_aux, 1'b0);
      fault = 1'b0;
      pwm_req = 1'b0;
      step();
      chk("R10 stays low", out_main, 1'b0);
      chk("R8 flag untouched by fault", aux_clipped, 1'b0);
   endtask

   task automatic t_guard();
      set_dly(2);
      pwm_req = 1'b1;
      step();
      chk("R8 aux on", out_aux, 1'b1);
      repeat (99) step();
      chk("R8 aux at limit", out_aux, 1'b1);
      chk("R8 flag clear", aux_clipped, 1'b0);
      step();
      chk("R8 aux clipped", out_aux, 1'b0);
      chk("R8 main clipped", out_main, 1'b0);
      chk("R8 flag set", aux_clipped, 1'b1);
      repeat (10) begin
         step();
         chk("R8 hold low", out_aux, 1'b0);
      end
      pwm_req = 1'b0;
      step();
      pwm_req = 1'b1;
      step();
      chk("R8 rearm aux", out_aux, 1'b1);
      chk("R8 flag sticky", aux_clipped, 1'b1);
      pwm_req = 1'b0;
      repeat (6) step();
      chk("R8 idle", out_aux, 1'b0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_default();
      t_settings();
      t_mid_write();
      t_fault();
      t_abort();
      t_retrigger();
      t_coincide();
      t_guard();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule